// File: doc/BRIEF.md
# Mirror Unit Command Executor

This block sits behind the serial bus receiver of an exterior mirror unit. For each frame the receiver has decoded and checked, it gets a one-cycle strobe together with a 3-bit address field and a 5-bit command code. The block acts only on frames whose address equals the unit's strapped address, which is the only difference between the left and right units. It turns the known command codes into drive levels for the four plate motor directions, the two fold motor directions and the wiper. In the same cycle that an action starts, it asks the transmitter to send an acknowledge frame that echoes the accepted address and code.

The motor driver reports overcurrent and overtemperature on two active-low lines. Either line going low removes every drive output in the same cycle, ahead of any command. The shutdown then stays latched until both lines are high again and a stop command arrives. A motion watchdog drops the plate and fold outputs when the keyboard stops refreshing them, which covers a lost bus or a lost keyboard.

Top module: `mirror_cmd_exec`

## Requirements
- R1: A frame whose address differs from `strap_addr_i` changes no output and raises no acknowledge.
- R2: The plate codes are 00010 (up), 00100 (down), 00110 (left) and 01000 (right). An accepted plate code drives its output from the cycle after the strobe. At most one plate output is high at a time, and a new plate code replaces the previous one.
- R3: Code 01110 turns the wiper on and code 10000 turns it off. The wiper is a level, and the motion watchdog does not clear it.
- R4: Code 01010 (fold/open) is a new press when the previous accepted code differed. A new press starts the fold motor and reverses its direction, so the first press after reset drives `fold_a_o` and the next drives `fold_b_o`. Repeated frames with the same code keep the direction. The two fold outputs are never high together.
- R5: Code 10010 (stop) clears all plate, fold and wiper outputs.
- R6: Every accepted known code raises `ack_req_o` for exactly one cycle, the cycle after the strobe. `ack_addr_o` and `ack_data_o` then echo the received fields.
- R7: An unknown code has no effect on the outputs and raises no acknowledge.
- R8: While `dg_oc_ni` or `dg_ot_ni` is low, all drive outputs are low, with no clock edge needed.
- R9: A fault latches a shutdown. While it is latched, every code except stop is ignored and gets no acknowledge. An accepted stop clears the latch only when both fault lines are high.
- R10: The plate and fold outputs drop WDOG_CYC cycles after the last accepted plate or fold code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strap_addr_i | input | ADDR_W | Strapped unit address |
| frm_valid_i | input | 1 | One-cycle strobe marking a checked frame |
| frm_addr_i | input | ADDR_W | Received address field |
| frm_data_i | input | 5 | Received command code |
| dg_oc_ni | input | 1 | Driver overcurrent, active low |
| dg_ot_ni | input | 1 | Driver overtemperature, active low |
| plate_up_o | output | 1 | Plate up drive |
| plate_dn_o | output | 1 | Plate down drive |
| plate_lt_o | output | 1 | Plate left drive |
| plate_rt_o | output | 1 | Plate right drive |
| fold_a_o | output | 1 | Fold motor, first direction |
| fold_b_o | output | 1 | Fold motor, second direction |
| wiper_o | output | 1 | Wiper drive |
| ack_req_o | output | 1 | Request to send an acknowledge frame |
| ack_addr_o | output | ADDR_W | Acknowledge address field |
| ack_data_o | output | 5 | Acknowledge command code |

## Verification
Command results and the acknowledge pulse appear one register stage after the sampling edge of the strobe. The bench therefore checks them on the falling edge right after that sampling edge, and checks one cycle later that the acknowledge has gone low. A fault kill has no register in its path, so the bench checks it 1 ns after a fault line falls, before any clock edge. The bench then checks the latched shutdown once the line has been released. For the watchdog, the outputs are checked as still high half a cycle before edge WDOG_CYC after the strobe's sampling edge, and as low half a cycle after that edge. The wiper is checked after the same wait to show that the watchdog leaves it on.

// File: rtl/mirror_cmd_pkg.sv
package mirror_cmd_pkg;
  localparam int CODE_W = 5;

  localparam logic [CODE_W-1:0] C_UP      = 5'b00010;
  localparam logic [CODE_W-1:0] C_DN      = 5'b00100;
  localparam logic [CODE_W-1:0] C_LT      = 5'b00110;
  localparam logic [CODE_W-1:0] C_RT      = 5'b01000;
  localparam logic [CODE_W-1:0] C_FOLD    = 5'b01010;
  localparam logic [CODE_W-1:0] C_WIP_ON  = 5'b01110;
  localparam logic [CODE_W-1:0] C_WIP_OFF = 5'b10000;
  localparam logic [CODE_W-1:0] C_STOP    = 5'b10010;

  typedef enum logic [3:0] {
    CMD_NONE, CMD_UP, CMD_DN, CMD_LT, CMD_RT,
    CMD_FOLD, CMD_WIP_ON, CMD_WIP_OFF, CMD_STOP
  } cmd_e;
endpackage

// File: rtl/mc_cmd_decode.sv
module mc_cmd_decode
  import mirror_cmd_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] strap_i,
  input  logic [CODE_W-1:0] data_i,
  output logic              hit_o,
  output cmd_e              cmd_o
);
  always_comb begin
    unique case (data_i)
      C_UP:      cmd_o = CMD_UP;
      C_DN:      cmd_o = CMD_DN;
      C_LT:      cmd_o = CMD_LT;
      C_RT:      cmd_o = CMD_RT;
      C_FOLD:    cmd_o = CMD_FOLD;
      C_WIP_ON:  cmd_o = CMD_WIP_ON;
      C_WIP_OFF: cmd_o = CMD_WIP_OFF;
      C_STOP:    cmd_o = CMD_STOP;
      default:   cmd_o = CMD_NONE;
    endcase
  end

  assign hit_o = valid_i && (addr_i == strap_i) && (cmd_o != CMD_NONE);
endmodule

// File: rtl/mc_fault_latch.sv
module mc_fault_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oc_ni,
  input  logic ot_ni,
  input  logic stop_acc_i,
  output logic fault_now_o,
  output logic fault_lat_o
);
  assign fault_now_o = !oc_ni || !ot_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          fault_lat_o <= 1'b0;
    else if (fault_now_o) fault_lat_o <= 1'b1;
    else if (stop_acc_i)  fault_lat_o <= 1'b0;
  end

  // R9
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_lat_o && !stop_acc_i) |=> fault_lat_o);
endmodule

// File: rtl/mc_motion_wdog.sv
module mc_motion_wdog #(
  parameter int WDOG_CYC = 37_500_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic refresh_i,
  input  logic active_i,
  output logic expire_o
);
  localparam int CNT_W = (WDOG_CYC > 2) ? $clog2(WDOG_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WDOG_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (refresh_i)                 cnt_q <= '0;
    else if (active_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = active_i && !refresh_i && (cnt_q == LAST);

  // R10
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/mirror_cmd_exec.sv
module mirror_cmd_exec
  import mirror_cmd_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int WDOG_CYC = 37_500_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] strap_addr_i,
  input  logic              frm_valid_i,
  input  logic [ADDR_W-1:0] frm_addr_i,
  input  logic [4:0]        frm_data_i,
  input  logic              dg_oc_ni,
  input  logic              dg_ot_ni,
  output logic              plate_up_o,
  output logic              plate_dn_o,
  output logic              plate_lt_o,
  output logic              plate_rt_o,
  output logic              fold_a_o,
  output logic              fold_b_o,
  output logic              wiper_o,
  output logic              ack_req_o,
  output logic [ADDR_W-1:0] ack_addr_o,
  output logic [4:0]        ack_data_o
);
  logic        hit, acc, fault_now, fault_lat, expire, refresh, kill;
  cmd_e        cmd;
  logic [3:0]  plate_q;  // {rt, lt, dn, up}
  logic        fold_run_q, fold_dir_q, wiper_q;
  logic [CODE_W-1:0] last_q;

  mc_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
    .valid_i(frm_valid_i), .addr_i(frm_addr_i), .strap_i(strap_addr_i),
    .data_i(frm_data_i), .hit_o(hit), .cmd_o(cmd)
  );

  // latched shutdown lets only stop through
  assign acc = hit && !fault_now && (!fault_lat || cmd == CMD_STOP);

  mc_fault_latch u_flt (
    .clk_i(clk_i), .rst_ni(rst_ni), .oc_ni(dg_oc_ni), .ot_ni(dg_ot_ni),
    .stop_acc_i(acc && cmd == CMD_STOP),
    .fault_now_o(fault_now), .fault_lat_o(fault_lat)
  );

  assign refresh = acc && (cmd inside {CMD_UP, CMD_DN, CMD_LT, CMD_RT, CMD_FOLD});

  mc_motion_wdog #(.WDOG_CYC(WDOG_CYC)) u_wdog (
    .clk_i(clk_i), .rst_ni(rst_ni), .refresh_i(refresh),
    .active_i((|plate_q) || fold_run_q), .expire_o(expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      plate_q    <= '0;
      fold_run_q <= 1'b0;
      fold_dir_q <= 1'b0;
      wiper_q    <= 1'b0;
      last_q     <= '0;
      ack_req_o  <= 1'b0;
      ack_addr_o <= '0;
      ack_data_o <= '0;
    end else if (fault_now) begin
      plate_q    <= '0;
      fold_run_q <= 1'b0;
      wiper_q    <= 1'b0;
      last_q     <= '0;
      ack_req_o  <= 1'b0;
    end else begin
      ack_req_o <= acc;
      if (expire) begin
        plate_q    <= '0;
        fold_run_q <= 1'b0;
      end
      if (acc) begin
        ack_addr_o <= frm_addr_i;
        ack_data_o <= frm_data_i;
        last_q     <= frm_data_i;
        unique case (cmd)
          CMD_UP:      plate_q <= 4'b0001;
          CMD_DN:      plate_q <= 4'b0010;
          CMD_LT:      plate_q <= 4'b0100;
          CMD_RT:      plate_q <= 4'b1000;
          CMD_FOLD: begin
            fold_run_q <= 1'b1;
            if (last_q != C_FOLD) fold_dir_q <= !fold_dir_q;
          end
          CMD_WIP_ON:  wiper_q <= 1'b1;
          CMD_WIP_OFF: wiper_q <= 1'b0;
          CMD_STOP: begin
            plate_q    <= '0;
            fold_run_q <= 1'b0;
            wiper_q    <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  // immediate kill path, no register
  assign kill       = fault_now || fault_lat;
  assign plate_up_o = plate_q[0] && !kill;
  assign plate_dn_o = plate_q[1] && !kill;
  assign plate_lt_o = plate_q[2] && !kill;
  assign plate_rt_o = plate_q[3] && !kill;
  assign fold_a_o   = fold_run_q && fold_dir_q && !kill;
  assign fold_b_o   = fold_run_q && !fold_dir_q && !kill;
  assign wiper_o    = wiper_q && !kill;

  // R2
  plate_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({plate_up_o, plate_dn_o, plate_lt_o, plate_rt_o}));
  // R4
  fold_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fold_a_o && fold_b_o));
  // R1
  addr_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_valid_i && frm_addr_i != strap_addr_i) |=> !ack_req_o);
  // R6
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_req_o |=> (!ack_req_o || $past(frm_valid_i)));
  // R8
  fault_kill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dg_oc_ni || !dg_ot_ni) |-> !(plate_up_o || plate_dn_o || plate_lt_o ||
      plate_rt_o || fold_a_o || fold_b_o || wiper_o));
  // R9
  fault_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_lat && frm_valid_i && frm_data_i != C_STOP) |=> !ack_req_o);
endmodule

// File: tb/mirror_cmd_exec_tb.sv
module mirror_cmd_exec_tb;
  localparam int W = 40;
  localparam logic [2:0] MY = 3'd5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic vld = 1'b0;
  logic [2:0] addr = '0;
  logic [4:0] data = '0;
  logic oc_n = 1'b1, ot_n = 1'b1;
  logic up, dn, lt, rt, fa, fb, wp, ack;
  logic [2:0] ack_a;
  logic [4:0] ack_d;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  mirror_cmd_exec #(.ADDR_W(3), .WDOG_CYC(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .strap_addr_i(MY),
    .frm_valid_i(vld), .frm_addr_i(addr), .frm_data_i(data),
    .dg_oc_ni(oc_n), .dg_ot_ni(ot_n),
    .plate_up_o(up), .plate_dn_o(dn), .plate_lt_o(lt), .plate_rt_o(rt),
    .fold_a_o(fa), .fold_b_o(fb), .wiper_o(wp),
    .ack_req_o(ack), .ack_addr_o(ack_a), .ack_data_o(ack_d)
  );

  function automatic logic [6:0] outs();
    return {up, dn, lt, rt, fa, fb, wp};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // leaves time half a cycle after the sampling edge
  task automatic send(input logic [2:0] a, input logic [4:0] d);
    @(negedge clk); vld = 1'b1; addr = a; data = d;
    @(negedge clk); vld = 1'b0;
  endtask

  task automatic t_reset();
    chk("R5 reset outs", 32'(outs()), 0);
    chk("R6 reset ack", 32'(ack), 0);
  endtask

  task automatic t_addr();
    send(3'd2, 5'b00010);
    chk("R1 miss outs", 32'(outs()), 0);
    chk("R1 miss ack", 32'(ack), 0);
  endtask

  task automatic t_plate();
    send(MY, 5'b00010);
    chk("R2 up", 32'(outs()), 32'b1000000);
    chk("R6 ack", 32'(ack), 1);
    chk("R6 echo", 32'({ack_a, ack_d}), 32'({MY, 5'b00010}));
    @(negedge clk);
    chk("R6 ack one cycle", 32'(ack), 0);
    send(MY, 5'b00110);
    chk("R2 replace by left", 32'(outs()), 32'b0010000);
    send(MY, 5'b01000);
    chk("R2 right", 32'(outs()), 32'b0001000);
    send(MY, 5'b00100);
    chk("R2 down", 32'(outs()), 32'b0100000);
    send(MY, 5'b10010);
    chk("R5 stop", 32'(outs()), 0);
    chk("R6 stop ack", 32'(ack), 1);
  endtask

  task automatic t_wiper();
    send(MY, 5'b01110);
    chk("R3 wiper on", 32'(wp), 1);
    repeat (W + 10) @(negedge clk);
    chk("R3 wiper survives watchdog", 32'(wp), 1);
    send(MY, 5'b10000);
    chk("R3 wiper off", 32'(wp), 0);
  endtask

  task automatic t_fold();
    send(MY, 5'b01010);
    chk("R4 first press", 32'({fa, fb}), 32'b10);
    send(MY, 5'b01010);
    chk("R4 repeat keeps", 32'({fa, fb}), 32'b10);
    send(MY, 5'b10010);
    send(MY, 5'b01010);
    chk("R4 second press", 32'({fa, fb}), 32'b01);
    send(MY, 5'b10010);
  endtask

  task automatic t_unknown();
    send(MY, 5'b11111);
    chk("R7 unknown outs", 32'(outs()), 0);
    chk("R7 unknown ack", 32'(ack), 0);
  endtask

  task automatic t_wdog();
    send(MY, 5'b00100);
    repeat (W - 1) @(negedge clk);
    chk("R10 still on", 32'(dn), 1);
    @(negedge clk);
    chk("R10 expired", 32'(dn), 0);
  endtask

  task automatic t_fault();
    send(MY, 5'b00010);
    send(MY, 5'b01110);
    #1 oc_n = 1'b0;
    #1 chk("R8 kill", 32'(outs()), 0);
    @(negedge clk); oc_n = 1'b1;
    @(negedge clk);
    chk("R9 latched", 32'(outs()), 0);
    send(MY, 5'b01000);
    chk("R9 ignored outs", 32'(outs()), 0);
    chk("R9 ignored ack", 32'(ack), 0);
    ot_n = 1'b0;
    send(MY, 5'b10010);
    chk("R9 stop while fault no ack", 32'(ack), 0);
    ot_n = 1'b1;
    send(MY, 5'b01000);
    chk("R9 still latched", 32'(outs()), 0);
    send(MY, 5'b10010);
    chk("R9 clear ack", 32'(ack), 1);
    send(MY, 5'b01000);
    chk("R9 after clear", 32'(outs()), 32'b0001000);
    send(MY, 5'b10010);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_addr();
        t_plate();
        t_wiper();
        t_fold();
        t_unknown();
        t_wdog();
        t_fault();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog timeout actual=1 expected=0");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule